// File: doc/BRIEF.md
# Half-Rate Interleaved PRBS7 Source

This block produces a maximal-length seven-bit pseudo-random bit stream at twice the rate of its only clock. Two independent seven-stage feedback registers run on that clock. One holds the bits at even positions of the stream and the other holds the bits at odd positions. Both use the same feedback taps, because taking every second bit of a maximal sequence gives a sequence that obeys the same recurrence. Each enabled clock edge yields a two-bit word that carries one even bit and one odd bit. An optional serial output picks one of the two word bits by the level of the clock, which gives the full-rate stream with no second clock.

The start input is asynchronous. While it is high, both loops hold a seed derived from the parameter SEED, so the loops cannot stay in the all-zero state that a cold register would otherwise keep. The enable input pauses the stream without losing its place.

Top module: `prbs_hr_gen`

## Requirements
- R1: While `start` is high, `word_out` is 0 and `word_valid` is 0, and this takes effect without waiting for a clock edge.
- R2: At the first rising edge after `start` falls with `adv_en` high, `word_out` becomes word 0 and `word_valid` becomes 1.
- R3: Define the serial reference by s[n] = SEED bit n for n < 7, and s[n] = s[n-6] XOR s[n-7] otherwise (polynomial x^7 + x^6 + 1). The default SEED is all ones. Word k is {s[2k+1], s[2k]}: bit 0 carries the even bit and bit 1 carries the odd bit.
- R4: Over any 127 consecutive words, the 254-bit stream of even bit then odd bit repeats with period 127. No 7-bit window of it is all zero, and each of the 127 nonzero 7-bit patterns starts at exactly one offset.
- R5: A rising edge with `adv_en` low leaves `word_out` and `word_valid` unchanged. The next enabled edge presents the next word, with none skipped.
- R6: When SER_EN is 1, `ser_out` equals `word_out[0]` while `clk` is high and `word_out[1]` while `clk` is low. The even bit is therefore sent first in each clock period.
- R7: Once a word is valid, neither feedback loop is ever all zero.
- R8: Raising `start` in the middle of a run returns the block to its start state. The stream restarts from word 0 after the release.
- R9: A change of clock period in the middle of a run does not alter the sequence, and no realignment is needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-rate clock for both loops; also the select of the serial mux |
| start | input | 1 | Asynchronous start: seeds both loops and clears the word while high |
| adv_en | input | 1 | Advance enable; when low, the stream pauses |
| word_out | output | 2 | {odd bit, even bit} of the current word |
| word_valid | output | 1 | High once a word has been produced after start |
| ser_out | output | 1 | Full-rate serial bit chosen by clock level |

## Verification
The all-zero lock cannot be reached from the ports, because start always seeds a nonzero state. The bench therefore covers it another way: it sweeps two full periods and checks that every 7-bit window of the collected stream is nonzero and unique, and an assertion watches both loops. The odd-before-even ordering fault is caught by sampling the serial output in both clock phases. Pauses come from random enable patterns with a fixed seed. A restart mid-stream and a stretched clock segment check that the block needs no realignment.

// File: rtl/prbs_hr_pkg.sv
package prbs_hr_pkg;
  localparam int WMAX = 32;
  typedef logic [WMAX-1:0]   win_t;
  typedef logic [2*WMAX-1:0] seq_t;

  // First 2*len bits of the serial sequence s[n] = s[n-tap] ^ s[n-len]
  function automatic seq_t expand_seq(input win_t seed, input int len, input int tap);
    seq_t s;
    s = '0;
    for (int n = 0; n < 2*len; n++) begin
      if (n < len) s[n] = seed[n];
      else         s[n] = s[n-tap] ^ s[n-len];
    end
    return s;
  endfunction

  // Pick every second bit starting at phase (0 = even, 1 = odd)
  function automatic win_t decimate(input seq_t s, input int len, input int phase);
    win_t d;
    d = '0;
    for (int i = 0; i < len; i++) d[i] = s[2*i + phase];
    return d;
  endfunction

  // Advance a look-ahead window: w[0] is the current bit, w[i] the bit i steps later
  function automatic win_t next_window(input win_t w, input int len, input int tap);
    win_t n;
    n = '0;
    for (int i = 0; i < len - 1; i++) n[i] = w[i+1];
    n[len-1] = w[len-tap] ^ w[0];
    return n;
  endfunction
endpackage

// File: rtl/prbs_hr_loop.sv
module prbs_hr_loop
  import prbs_hr_pkg::*;
#(
  parameter int LEN = 7,
  parameter int TAP = 6,
  parameter logic [LEN-1:0] SEED = '1
) (
  input  logic           clk,
  input  logic           start,
  input  logic           adv,
  output logic [LEN-1:0] win
);
  logic [LEN-1:0] st_q;
  win_t           nxt_wide;

  always_comb nxt_wide = next_window(win_t'(st_q), LEN, TAP);

  always_ff @(posedge clk or posedge start) begin
    if (start)    st_q <= SEED;
    else if (adv) st_q <= nxt_wide[LEN-1:0];
  end

  assign win = st_q;
endmodule

// File: rtl/prbs_hr_wordreg.sv
module prbs_hr_wordreg (
  input  logic       clk,
  input  logic       start,
  input  logic       adv,
  input  logic       even_bit,
  input  logic       odd_bit,
  output logic [1:0] word,
  output logic       valid
);
  always_ff @(posedge clk or posedge start) begin
    if (start) begin
      word  <= 2'b00;
      valid <= 1'b0;
    end else if (adv) begin
      word  <= {odd_bit, even_bit};
      valid <= 1'b1;
    end
  end
endmodule

// File: rtl/prbs_hr_sermux.sv
module prbs_hr_sermux #(
  parameter bit SER_EN = 1'b1
) (
  input  logic       clk,
  input  logic [1:0] word,
  output logic       ser
);
  generate
    if (SER_EN) begin : g_mux
      assign ser = clk ? word[0] : word[1];
    end else begin : g_none
      logic unused_in;
      assign unused_in = clk ^ word[0] ^ word[1];
      assign ser = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/prbs_hr_gen.sv
module prbs_hr_gen
  import prbs_hr_pkg::*;
#(
  parameter int LEN = 7,
  parameter int TAP = 6,
  parameter logic [LEN-1:0] SEED = '1,
  parameter bit SER_EN = 1'b1
) (
  input  logic       clk,
  input  logic       start,
  input  logic       adv_en,
  output logic [1:0] word_out,
  output logic       word_valid,
  output logic       ser_out
);
  localparam seq_t SEQ0 = expand_seq(win_t'(SEED), LEN, TAP);

  logic [LEN-1:0] loop_win [0:1];
  logic [LEN-1:0] even_win;
  logic [LEN-1:0] odd_win;

  genvar ph;
  generate
    for (ph = 0; ph < 2; ph++) begin : g_loop
      localparam win_t PH_SEED = decimate(SEQ0, LEN, ph);
      prbs_hr_loop #(
        .LEN (LEN),
        .TAP (TAP),
        .SEED(PH_SEED[LEN-1:0])
      ) u_loop (
        .clk  (clk),
        .start(start),
        .adv  (adv_en),
        .win  (loop_win[ph])
      );
    end
  endgenerate

  assign even_win = loop_win[0];
  assign odd_win  = loop_win[1];

  prbs_hr_wordreg u_word (
    .clk     (clk),
    .start   (start),
    .adv     (adv_en),
    .even_bit(even_win[0]),
    .odd_bit (odd_win[0]),
    .word    (word_out),
    .valid   (word_valid)
  );

  prbs_hr_sermux #(.SER_EN(SER_EN)) u_ser (
    .clk (clk),
    .word(word_out),
    .ser (ser_out)
  );
endmodule

// File: rtl/prbs_hr_chk.sv
module prbs_hr_chk #(
  parameter int LEN = 7,
  parameter int TAP = 6
) (
  input logic           clk,
  input logic           start,
  input logic           adv_en,
  input logic [1:0]     word_out,
  input logic           word_valid,
  input logic [LEN-1:0] even_win,
  input logic [LEN-1:0] odd_win
);
  // R1
  always @(negedge clk) begin
    if (start) begin
      start_clear_chk: assert (word_out == 2'b00 && !word_valid)
        else $error("word not cleared during start");
    end
  end

  // R7
  loops_nonzero_chk: assert property (@(posedge clk) disable iff (start)
    word_valid |-> (|even_win) && (|odd_win))
    else $error("feedback loop reached all zero");

  // R5
  pause_hold_chk: assert property (@(posedge clk) disable iff (start)
    !adv_en |=> $stable(word_out) && $stable(word_valid))
    else $error("word moved while paused");

  // R2
  valid_after_adv_chk: assert property (@(posedge clk) disable iff (start)
    adv_en |=> word_valid)
    else $error("valid missing after enabled edge");

  generate
    if (LEN == 7 && TAP == 6) begin : g_x7
      // R3
      even_interleave_chk: assert property (@(posedge clk) disable iff (start)
        even_win[4] == (even_win[1] ^ odd_win[0]))
        else $error("even loop out of step with odd loop");

      // R3
      odd_interleave_chk: assert property (@(posedge clk) disable iff (start)
        odd_win[3] == (odd_win[0] ^ even_win[0]))
        else $error("odd loop out of step with even loop");
    end
  endgenerate
endmodule

bind prbs_hr_gen prbs_hr_chk #(.LEN(LEN), .TAP(TAP)) u_chk (
  .clk       (clk),
  .start     (start),
  .adv_en    (adv_en),
  .word_out  (word_out),
  .word_valid(word_valid),
  .even_win  (even_win),
  .odd_win   (odd_win)
);

// File: tb/prbs_hr_gen_bench.sv
`timescale 1ns/1ps
module prbs_hr_gen_bench;
  logic       clk = 1'b0;
  logic       start = 1'b1;
  logic       adv_en = 1'b0;
  logic [1:0] word_out;
  logic       word_valid;
  logic       ser_out;
  int         half_ns = 4;
  int         checks = 0;
  int         failures = 0;
  logic       ref_s [0:126];
  logic       strm [0:253];
  int         cur;

  prbs_hr_gen u_prbs_hr_gen (
    .clk(clk), .start(start), .adv_en(adv_en),
    .word_out(word_out), .word_valid(word_valid), .ser_out(ser_out)
  );

  always #(half_ns) clk = ~clk;

  // serial reference: shift register holding the last 7 bits, newest bit from taps 6 and 7 back
  task automatic build_ref();
    logic [6:0] hist;
    hist = 7'h7F;
    for (int n = 0; n < 127; n++) begin
      if (n < 7) ref_s[n] = 1'b1;
      else begin
        ref_s[n] = hist[5] ^ hist[6];
      end
      hist = {hist[5:0], ref_s[n]};
    end
  endtask

  function automatic logic [1:0] exp_word(input int k);
    return {ref_s[(2*k+1) % 127], ref_s[(2*k) % 127]};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    build_ref();
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    chk("R1 word during start", 32'(word_out), 0);
    chk("R1 valid during start", 32'(word_valid), 0);

    // two full periods with enable held high
    @(negedge clk); start = 1'b0; adv_en = 1'b1;
    for (int k = 0; k < 127; k++) begin
      @(posedge clk); #1;
      if (k == 0) chk("R2 first word valid", 32'(word_valid), 1);
      chk("R3 word", 32'(word_out), 32'(exp_word(k)));
      chk("R6 ser high phase even", 32'(ser_out), 32'(ref_s[(2*k) % 127]));
      strm[2*k] = ser_out;
      @(negedge clk); #1;
      chk("R6 ser low phase odd", 32'(ser_out), 32'(ref_s[(2*k+1) % 127]));
      strm[2*k+1] = ser_out;
    end
    cur = 126;

    // R4 and R7: windows nonzero and unique
    begin
      logic [127:0] seen;
      int dup;
      int zero;
      seen = '0; dup = 0; zero = 0;
      for (int p = 0; p < 127; p++) begin
        logic [6:0] w;
        for (int j = 0; j < 7; j++) w[j] = strm[p+j];
        if (w == 0) zero++;
        if (seen[w]) dup++;
        seen[w] = 1'b1;
      end
      chk("R7 zero windows", 32'(zero), 0);
      chk("R4 duplicate windows", 32'(dup), 0);
      chk("R4 distinct patterns", 32'($countones(seen)), 127);
      for (int p = 0; p < 127; p++) begin
        checks++;
        if (strm[p] !== strm[p+127]) begin
          failures++;
          $display("FAIL R4 period bit %0d actual=%0b expected=%0b", p, strm[p+127], strm[p]);
        end
      end
    end

    // R5 random pauses
    for (int c = 0; c < 400; c++) begin
      logic en_now;
      en_now = 1'($urandom % 2);
      adv_en = en_now;
      @(posedge clk); #1;
      if (en_now) cur++;
      chk("R5 word with pauses", 32'(word_out), 32'(exp_word(cur)));
      chk("R5 valid held", 32'(word_valid), 1);
      @(negedge clk); #1;
    end

    // R9 stretched clock then back
    adv_en = 1'b1;
    half_ns = 10;
    for (int c = 0; c < 60; c++) begin
      @(posedge clk); #1;
      cur++;
      chk("R9 word slow clock", 32'(word_out), 32'(exp_word(cur)));
      @(negedge clk); #1;
    end
    half_ns = 4;
    for (int c = 0; c < 20; c++) begin
      @(posedge clk); #1;
      cur++;
      chk("R9 word after speed-up", 32'(word_out), 32'(exp_word(cur)));
      @(negedge clk); #1;
    end

    // R8 restart mid-stream
    start = 1'b1; #1;
    chk("R8 async clear word", 32'(word_out), 0);
    chk("R1 async clear valid", 32'(word_valid), 0);
    @(posedge clk); #1;
    chk("R8 held in start", 32'(word_out), 0);
    @(negedge clk); start = 1'b0;
    for (int k = 0; k < 10; k++) begin
      @(posedge clk); #1;
      chk("R8 restart sequence", 32'(word_out), 32'(exp_word(k)));
      @(negedge clk); #1;
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule